// File: doc/BRIEF.md
# Six-Channel Compare/Capture Timer

This block holds six independent 16-bit up-counters. Each counter runs only while its bit in a shared run register is set. Every channel carries general registers that compare against the counter to drive a pin, or capture the counter on a pin edge. Channels 0 and 3 have four such registers (slots A, B, C, D). The others have two (A, B). On the four-register channels, slot C can act as a buffer for A and slot D as a buffer for B, so the next compare value or the previous captured value is staged without software racing the hardware.

Software reaches the block over a simple synchronous register bus. `bus_addr[6:4]` selects a channel (0 to 5), and the value 7 selects the global page. `bus_addr[3:0]` selects a register inside the page. Counters and general registers accept only full 16-bit accesses. The run register, the per-slot pin settings and the buffer pairing setting also accept byte accesses, and take the low byte. Each slot has its own pin pair: `pin_in` and `pin_out` bit `4*ch+slot`, with slot 0=A, 1=B, 2=C, 3=D.

Top module: `tpu6_top`

## Requirements
- R1: After reset all counters read 0x0000, the run register reads 0, every general register reads 0xFFFF, every pin setting reads 0 and every `pin_out` bit is 0.
- R2: The run register sits at address 0x70. Bit n (n = 0..5) runs channel n. Bits 7:6 always read 0, whatever is written to them.
- R3: A channel counter (offset 0) adds one on each clock while its run bit is 1, and wraps from 0xFFFF to 0x0000. A bus write to the counter in the same cycle wins over the increment.
- R4: While its run bit is 0, a counter keeps its value.
- R5: Counters and general registers (offsets 1..4 for A..D) ignore writes made with `bus_wide`=0, and return 0x0000 on reads made with `bus_wide`=0.
- R6: While `standby` is 1, every counter is held at 0x0000.
- R7: A slot's pin setting is at offset 5+slot. Bit 3=0 selects compare. Bits 1:0 give the match action: 00 none, 01 drive low, 10 drive high, 11 toggle. The pin changes at the clock edge that ends the cycle in which the running counter equals the register.
- R8: Clearing a channel's run bit leaves its compare pins at their current levels.
- R9: Writing a slot's pin setting while its channel is stopped sets the pin to bit 2 of the new setting at that write's clock edge. The same write while the channel is running leaves the pin unchanged.
- R10: Pin setting bit 3=1 selects capture. Bits 1:0 choose the edge: 01 rising, 10 falling, 11 both. A selected edge (the pin differs from its previous clock sample) loads the count of that cycle into the register. Edges that are not selected leave the register unchanged.
- R11: On channels 0 and 3, pairing setting (offset 9) bit 0 pairs C as buffer of A and bit 1 pairs D as buffer of B. A compare match on a paired A or B copies its buffer into it.
- R12: A capture on a paired A or B first moves its old value into the buffer, then loads the count.
- R13: On two-register channels, the pairing setting and slots C and D read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Holds all counters at zero |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_rd | input | 1 | Read strobe, data is combinational |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 7 | Page in [6:4], register in [3:0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when not reading |
| pin_in | input | 24 | Capture inputs, bit 4*ch+slot |
| pin_out | output | 24 | Compare outputs, bit 4*ch+slot |

## Verification
The bench builds the block with its defaults: six channels, 16-bit counters, and four-register layout on channels 0 and 3. That mix puts a buffered compare, a buffered capture and the missing-slot behaviour of a two-register channel in the same run. With a 16-bit counter, the bench reaches the wrap point by preloading 0xFFFE instead of waiting through the full range. Each compare and capture case starts from a known counter value, so the expected pin edge and captured value follow from counting clock edges.

// File: rtl/tpu6_pkg.sv
package tpu6_pkg;
   // per-slot pin setting: [3] capture, [2] initial level, [1:0] action/edge
   typedef struct packed {
      logic       cap;
      logic       init;
      logic [1:0] sel;
   } ioc_t;

   typedef enum logic [1:0] {
      ACT_NONE = 2'b00,
      ACT_LOW  = 2'b01,
      ACT_HIGH = 2'b10,
      ACT_TOG  = 2'b11
   } act_e;

   localparam int SLOTS     = 4;
   localparam int OFS_CNT   = 0;
   localparam int OFS_GR0   = 1;
   localparam int OFS_IO0   = 5;
   localparam int OFS_PAIR  = 9;
   localparam int PAGE_GLOB = 7;
endpackage

// File: rtl/tpu6_counter.sv
module tpu6_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          standby,
   input  logic          run,
   input  logic          wr_en,
   input  logic [CW-1:0] wr_val,
   output logic [CW-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (standby) cnt <= '0;
      else if (wr_en)   cnt <= wr_val;
      else if (run)     cnt <= cnt + 1'b1;
   end

   a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_en && !standby) |=> cnt == $past(cnt));
   a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wr_en && !standby && cnt == '1) |=> cnt == '0);
   a_r6_standby_zero: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> cnt == '0);
endmodule

// File: rtl/tpu6_pinctl.sv
module tpu6_pinctl
   import tpu6_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          active,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] regv,
   input  ioc_t          ioc,
   input  logic          ioc_wr,
   input  ioc_t          ioc_new,
   input  logic          pin_in,
   output logic          pin_out,
   output logic          match,
   output logic          cap
);
   logic prev_q;
   logic rise, fall;

   assign rise  = pin_in & ~prev_q;
   assign fall  = ~pin_in & prev_q;
   assign match = active && run && !ioc.cap && (cnt == regv);
   assign cap   = active && ioc.cap && ((ioc.sel[0] && rise) || (ioc.sel[1] && fall));

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_out <= 1'b0;
      end else if (ioc_wr && !run) begin
         pin_out <= ioc_new.init;
      end else if (match) begin
         unique case (act_e'(ioc.sel))
            ACT_NONE: pin_out <= pin_out;
            ACT_LOW:  pin_out <= 1'b0;
            ACT_HIGH: pin_out <= 1'b1;
            ACT_TOG:  pin_out <= ~pin_out;
         endcase
      end
   end

   a_r8_pin_kept_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ioc_wr) |=> $stable(pin_out));
   a_r9_init_on_stopped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && ioc_wr) |=> pin_out == $past(ioc_new.init));
   a_r9_running_write_no_force: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ioc_wr && !match) |=> $stable(pin_out));
endmodule

// File: rtl/tpu6_chan.sv
module tpu6_chan
   import tpu6_pkg::*;
#(
   parameter int CW  = 16,
   parameter int NGR = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               standby,
   input  logic               run,
   input  logic               wr_en,
   input  logic               wide,
   input  logic [3:0]         ofs,
   input  logic [CW-1:0]      wdata,
   input  logic [SLOTS-1:0]   pin_in,
   output logic [SLOTS-1:0]   pin_out,
   output logic [CW-1:0]      cnt_o,
   output logic [SLOTS*CW-1:0] gr_o,
   output logic [SLOTS*4-1:0] ioc_o,
   output logic [1:0]         pair_o
);
   localparam bit HAS_PAIR = (NGR == SLOTS);

   logic [CW-1:0]    gr    [SLOTS];
   ioc_t             ioc   [SLOTS];
   logic [SLOTS-1:0] match, cap;
   logic [1:0]       pair_q;
   logic             cnt_wr;

   if (NGR != 2 && NGR != 4) begin : g_bad_ngr
      $error("tpu6_chan: NGR must be 2 or 4");
   end

   assign cnt_wr = wr_en && wide && (ofs == 4'(OFS_CNT));

   tpu6_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .standby(standby), .run(run),
      .wr_en(cnt_wr), .wr_val(wdata), .cnt(cnt_o)
   );

   if (HAS_PAIR) begin : g_pair
      always_ff @(posedge clk) begin
         if (!rst_n) pair_q <= '0;
         else if (wr_en && ofs == 4'(OFS_PAIR)) pair_q <= wdata[1:0];
      end
   end else begin : g_nopair
      assign pair_q = '0;
   end
   assign pair_o = pair_q;

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      localparam int  PK     = k ^ 2;          // partner slot
      localparam bit  IS_PRI = (k < 2);
      if (k < NGR) begin : g_live
         logic gr_wr, io_wr, bon, active;
         assign gr_wr  = wr_en && wide && (ofs == 4'(OFS_GR0 + k));
         assign io_wr  = wr_en && (ofs == 4'(OFS_IO0 + k));
         assign bon    = pair_q[k & 1];
         assign active = IS_PRI ? 1'b1 : !bon;

         always_ff @(posedge clk) begin
            if (!rst_n)      ioc[k] <= '0;
            else if (io_wr)  ioc[k] <= ioc_t'(wdata[3:0]);
         end

         always_ff @(posedge clk) begin
            if (!rst_n)                               gr[k] <= '1;
            else if (gr_wr)                           gr[k] <= wdata;
            else if (IS_PRI && cap[k])                gr[k] <= cnt_o;
            else if (IS_PRI && bon && match[k])       gr[k] <= gr[PK];
            else if (!IS_PRI && bon && cap[PK])       gr[k] <= gr[PK];
         end

         tpu6_pinctl #(.CW(CW)) u_pin (
            .clk(clk), .rst_n(rst_n), .run(run), .active(active),
            .cnt(cnt_o), .regv(gr[k]), .ioc(ioc[k]), .ioc_wr(io_wr),
            .ioc_new(ioc_t'(wdata[3:0])), .pin_in(pin_in[k]),
            .pin_out(pin_out[k]), .match(match[k]), .cap(cap[k])
         );

         if (!IS_PRI) begin : g_bufcap
            a_r12_old_value_to_buffer: assert property (@(posedge clk) disable iff (!rst_n)
               (bon && cap[PK] && !gr_wr) |=> gr[k] == $past(gr[PK]));
         end else begin : g_pricap
            a_r10_capture_loads_count: assert property (@(posedge clk) disable iff (!rst_n)
               (cap[k] && !gr_wr) |=> gr[k] == $past(cnt_o));
         end
      end else begin : g_dead
         assign gr[k]      = '0;
         assign ioc[k]     = '0;
         assign match[k]   = 1'b0;
         assign cap[k]     = 1'b0;
         assign pin_out[k] = 1'b0;
      end
      assign gr_o[k*CW +: CW] = gr[k];
      assign ioc_o[k*4 +: 4]  = ioc[k];
   end
endmodule

// File: rtl/tpu6_top.sv
module tpu6_top
   import tpu6_pkg::*;
#(
   parameter int               NCH       = 6,
   parameter int               CW        = 16,
   parameter logic [NCH-1:0]   QUAD_MASK = 6'b001001
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 standby,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic                 bus_wide,
   input  logic [6:0]           bus_addr,
   input  logic [CW-1:0]        bus_wdata,
   output logic [CW-1:0]        bus_rdata,
   input  logic [NCH*SLOTS-1:0] pin_in,
   output logic [NCH*SLOTS-1:0] pin_out
);
   localparam int NPIN = NCH * SLOTS;

   if (NCH < 1 || NCH > PAGE_GLOB) begin : g_bad_nch
      $error("tpu6_top: NCH must be 1..7");
   end
   if (CW < 8 || CW > 32) begin : g_bad_cw
      $error("tpu6_top: CW must be 8..32");
   end

   logic [2:0]          page;
   logic [3:0]          ofs;
   logic [NCH-1:0]      run_q;
   logic [CW-1:0]       cnt_a  [NCH];
   logic [SLOTS*CW-1:0] gr_a   [NCH];
   logic [SLOTS*4-1:0]  ioc_a  [NCH];
   logic [1:0]          pair_a [NCH];

   assign page = bus_addr[6:4];
   assign ofs  = bus_addr[3:0];

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= '0;
      else if (bus_wr && page == 3'(PAGE_GLOB) && ofs == 4'd0) run_q <= bus_wdata[NCH-1:0];
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int NG = QUAD_MASK[c] ? SLOTS : 2;
      tpu6_chan #(.CW(CW), .NGR(NG)) u_ch (
         .clk(clk), .rst_n(rst_n), .standby(standby), .run(run_q[c]),
         .wr_en(bus_wr && page == 3'(c)), .wide(bus_wide), .ofs(ofs),
         .wdata(bus_wdata), .pin_in(pin_in[c*SLOTS +: SLOTS]),
         .pin_out(pin_out[c*SLOTS +: SLOTS]), .cnt_o(cnt_a[c]),
         .gr_o(gr_a[c]), .ioc_o(ioc_a[c]), .pair_o(pair_a[c])
      );
   end

   always_comb begin
      logic [1:0] sidx;
      sidx      = 2'(ofs - 4'(OFS_GR0));
      bus_rdata = '0;
      if (bus_rd) begin
         if (page == 3'(PAGE_GLOB)) begin
            if (ofs == 4'd0) bus_rdata = CW'(run_q);
         end else if (32'(page) < NCH) begin
            if (ofs == 4'(OFS_CNT)) begin
               if (bus_wide) bus_rdata = cnt_a[page];
            end else if (ofs >= 4'(OFS_GR0) && ofs < 4'(OFS_IO0)) begin
               if (bus_wide) bus_rdata = gr_a[page][sidx*CW +: CW];
            end else if (ofs >= 4'(OFS_IO0) && ofs < 4'(OFS_PAIR)) begin
               sidx      = 2'(ofs - 4'(OFS_IO0));
               bus_rdata = CW'(ioc_a[page][sidx*4 +: 4]);
            end else if (ofs == 4'(OFS_PAIR)) begin
               bus_rdata = CW'(pair_a[page]);
            end
         end
      end
   end

   a_r5_byte_read_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wide && page != 3'(PAGE_GLOB) && ofs < 4'(OFS_IO0)) |-> bus_rdata == '0);
   a_r2_reserved_run_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && page == 3'(PAGE_GLOB) && ofs == 4'd0) |-> bus_rdata[CW-1:NCH] == '0);
   a_r1_pins_low_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> pin_out == NPIN'(0));
endmodule

// File: tb/tb_tpu6_top.sv
module tb_tpu6_top;
   localparam int PERIOD = 10;
   localparam logic [6:0] RUNREG = 7'h70;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        standby = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_wide = 1'b1;
   logic [6:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [23:0] pin_in = '0;
   logic [23:0] pin_out;
   logic [15:0] d;
   int total = 0, bad = 0;

   always #(PERIOD/2) clk = ~clk;

   tpu6_top dut (
      .clk(clk), .rst_n(rst_n), .standby(standby), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wide(bus_wide), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out)
   );

   function automatic logic [6:0] ra(input int ch, input int o);
      return {3'(ch), 4'(o)};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // called at a negedge; the write lands on the next posedge
   task automatic bw(input logic [6:0] a, input logic [15:0] v, input logic wide = 1'b1);
      bus_addr = a; bus_wdata = v; bus_wide = wide; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wide = 1'b1;
   endtask

   task automatic br(input logic [6:0] a, input logic wide = 1'b1);
      bus_addr = a; bus_wide = wide; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0; bus_wide = 1'b1;
   endtask

   task automatic t_reset;
      br(ra(0,0)); chk("R1 counter", d, 16'h0000);
      br(RUNREG);  chk("R1 run reg", d, 16'h0000);
      br(ra(1,1)); chk("R1 general reg", d, 16'hFFFF);
      br(ra(4,5)); chk("R1 pin setting", d, 16'h0000);
      chk("R1 pins", pin_out, 24'h0);
   endtask

   task automatic t_runreg;
      bw(RUNREG, 16'h00FF);
      br(RUNREG); chk("R2 reserved bits", d, 16'h003F);
      bw(RUNREG, 16'h0000);
   endtask

   task automatic t_count;
      bw(ra(2,0), 16'hFFFE);
      bw(RUNREG, 16'h0004);
      repeat (2) @(negedge clk);
      bw(RUNREG, 16'h0000);
      br(ra(2,0)); chk("R3 wrap", d, 16'h0001);
      bw(RUNREG, 16'h0004);
      bw(ra(2,0), 16'h1234);
      bw(RUNREG, 16'h0000);
      br(ra(2,0)); chk("R3 write wins", d, 16'h1235);
      repeat (3) @(negedge clk);
      br(ra(2,0)); chk("R4 hold", d, 16'h1235);
   endtask

   task automatic t_bytes;
      bw(ra(2,0), 16'h5555, 1'b0);
      br(ra(2,0));       chk("R5 byte write counter", d, 16'h1235);
      br(ra(2,0), 1'b0); chk("R5 byte read counter", d, 16'h0000);
      bw(ra(2,1), 16'h4444, 1'b0);
      br(ra(2,1));       chk("R5 byte write general", d, 16'hFFFF);
      br(ra(2,1), 1'b0); chk("R5 byte read general", d, 16'h0000);
   endtask

   task automatic t_standby;
      standby = 1'b1;
      bw(RUNREG, 16'h0004);
      repeat (3) @(negedge clk);
      br(ra(2,0)); chk("R6 standby", d, 16'h0000);
      bw(RUNREG, 16'h0000);
      standby = 1'b0;
   endtask

   task automatic t_compare;
      bw(ra(1,1), 16'h0010);
      bw(ra(1,0), 16'h000E);
      bw(ra(1,5), 16'h0002);            // compare, drive high, init 0
      chk("R9 init low", pin_out[4], 1'b0);
      bw(RUNREG, 16'h0002);
      @(negedge clk); chk("R7 before match a", pin_out[4], 1'b0);
      @(negedge clk); chk("R7 before match b", pin_out[4], 1'b0);
      @(negedge clk); chk("R7 high on match", pin_out[4], 1'b1);
      bw(ra(1,5), 16'h0000);            // running: no forcing
      chk("R9 running write", pin_out[4], 1'b1);
      bw(RUNREG, 16'h0000);
      repeat (2) @(negedge clk);
      chk("R8 kept after stop", pin_out[4], 1'b1);
      bw(ra(1,5), 16'h0000); chk("R9 stopped init 0", pin_out[4], 1'b0);
      bw(ra(1,5), 16'h0004); chk("R9 stopped init 1", pin_out[4], 1'b1);
      bw(ra(1,5), 16'h0003); chk("R9 toggle init", pin_out[4], 1'b0);
      bw(ra(1,0), 16'h000F);
      bw(RUNREG, 16'h0002);
      @(negedge clk); chk("R7 toggle wait", pin_out[4], 1'b0);
      @(negedge clk); chk("R7 toggle", pin_out[4], 1'b1);
      @(negedge clk); chk("R7 toggle once", pin_out[4], 1'b1);
      bw(RUNREG, 16'h0000);
   endtask

   task automatic t_capture;
      bw(ra(4,5), 16'h0009);            // capture rising
      bw(ra(4,0), 16'h0777);
      pin_in[16] = 1'b1; @(negedge clk);
      br(ra(4,1)); chk("R10 rising capture", d, 16'h0777);
      bw(ra(4,0), 16'h0888);
      pin_in[16] = 1'b0; @(negedge clk);
      br(ra(4,1)); chk("R10 falling ignored", d, 16'h0777);
      bw(ra(4,5), 16'h000A);            // capture falling
      pin_in[16] = 1'b1; @(negedge clk);
      br(ra(4,1)); chk("R10 rising ignored", d, 16'h0777);
      pin_in[16] = 1'b0; @(negedge clk);
      br(ra(4,1)); chk("R10 falling capture", d, 16'h0888);
   endtask

   task automatic t_buf_compare;
      bw(ra(0,1), 16'h0020);
      bw(ra(0,3), 16'h0055);
      bw(ra(0,9), 16'h0001);
      bw(ra(0,5), 16'h0002);
      bw(ra(0,0), 16'h001F);
      bw(RUNREG, 16'h0001);
      repeat (4) @(negedge clk);
      bw(RUNREG, 16'h0000);
      br(ra(0,1)); chk("R11 buffer into A", d, 16'h0055);
      chk("R11 pin on match", pin_out[0], 1'b1);
   endtask

   task automatic t_buf_capture;
      bw(ra(3,9), 16'h0001);
      bw(ra(3,5), 16'h000B);            // capture both edges
      bw(ra(3,1), 16'h1111);
      bw(ra(3,0), 16'h0ABC);
      pin_in[12] = 1'b1; @(negedge clk);
      br(ra(3,1)); chk("R12 A gets count", d, 16'h0ABC);
      br(ra(3,3)); chk("R12 C gets old A", d, 16'h1111);
   endtask

   task automatic t_two_reg;
      bw(ra(2,9), 16'h0003);
      br(ra(2,9)); chk("R13 pairing absent", d, 16'h0000);
      bw(ra(2,3), 16'h7777);
      br(ra(2,3)); chk("R13 slot C absent", d, 16'h0000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_runreg();
      t_count();
      t_bytes();
      t_standby();
      t_compare();
      t_capture();
      t_buf_compare();
      t_buf_capture();
      t_two_reg();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule